// File: doc/BRIEF.md
# Rotating-Window Register File

This block stores a power-of-two array of 32-bit physical registers. Only a window of sixteen of them is visible at any time. The window begins at a base position counted in groups of four registers. Each logical index from 0 to 15 is turned into a physical index by adding four times the base. The sum wraps modulo the physical register count, so a window that runs past the top of the array continues at physical register 0.

The base can be changed in four ways:
- a relative shift by a signed 8-bit amount;
- a relative shift by a signed 4-bit immediate;
- a direct load of a new position;
- a reload from a saved old-base field supplied by the processor status logic.

Every one of these values is reduced modulo the number of groups, so out-of-range values wrap instead of faulting. Two combinational read ports and one synchronous write port are all addressed by logical index. A write issued in the same cycle as a base change lands in the window that was in effect before the change.

Top module: `wrf_top`

## Requirements
- R1: While `rst` is high at a clock edge, the base becomes 0 and every physical register becomes 0. After reset, every logical index reads 0 at base 0.
- R2: Logical index i reads and writes physical register (4·base + i) mod PHYS_REGS.
- R3: With the default of 64 registers, a window at base 15 covers physical registers 60..63 and then 0..11. Logical 4 at base 15 is therefore the same register as logical 4 at base 14 + 1 group, and physical 0 is shared with logical 0 at base 0.
- R4: `rot_op` = 1 sets the base to (base + signed `rot_arg`) mod (PHYS_REGS/4). For example, 0 − 1 gives 15 and 1 − 128 gives 1.
- R5: `rot_op` = 2 sets the base to `rot_arg` mod (PHYS_REGS/4). For example, 0x23 gives 3.
- R6: `rot_op` = 3 adds the two's-complement 4-bit `rot_imm` (range −8..7) to the base, modulo the group count.
- R7: `rot_op` = 4 sets the base to `saved_base` mod (PHYS_REGS/4).
- R8: A write in the same cycle as a base change targets the physical register selected by the old base.
- R9: Both read ports are combinational and independent. A written value is visible on a read of the same physical register from the next cycle onward.
- R10: `rot_op` values 0, 5, 6 and 7 leave the base unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rot_op | input | 3 | Base command: 0 hold, 1 add signed arg, 2 load arg, 3 add signed imm, 4 reload saved |
| rot_arg | input | ARG_W | Signed delta or absolute position |
| rot_imm | input | 4 | Signed 4-bit rotate amount |
| saved_base | input | ARG_W | Saved old-base field |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write logical index |
| wr_data | input | 32 | Write data |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| win_base | output | log2(PHYS_REGS/4) | Current window base |

## Verification
The mapping is exercised by writing at one base and reading back at others. This separates a correct four-register group scale from an offset of one register, and a modulo wrap from a saturating or overflowing index. The base commands are driven with small deltas, negative deltas that cross zero, deltas far larger than the group count, and loads whose upper bits must be discarded. Together these show that every path masks its result. A write paired with a rotation, followed by a rotation back, tells the old-window rule apart from the new-window rule. A reset after data has been written confirms that storage is cleared as well as the base.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int WORD_W   = 32;
    localparam int LIDX_W   = 4;
    localparam int WIN_REGS = 16;

    typedef enum logic [2:0] {
        ROT_HOLD    = 3'd0,
        ROT_ADD     = 3'd1,
        ROT_LOAD    = 3'd2,
        ROT_IMM     = 3'd3,
        ROT_RESTORE = 3'd4
    } rot_op_e;

    typedef struct packed {
        logic              en;
        logic [LIDX_W-1:0] idx;
        logic [WORD_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
    parameter int BASE_W = 4,
    parameter int PHYS_W = 6
) (
    input  logic [BASE_W-1:0]         base,
    input  logic [wrf_pkg::LIDX_W-1:0] lidx,
    output logic [PHYS_W-1:0]         pidx
);
    // Group base scaled by four, plus the logical offset; truncation wraps.
    assign pidx = PHYS_W'({base, 2'b00}) + PHYS_W'(lidx);
endmodule

// File: rtl/wrf_base_ctrl.sv
module wrf_base_ctrl #(
    parameter int BASE_W = 4,
    parameter int ARG_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wrf_pkg::rot_op_e     op,
    input  logic [ARG_W-1:0]     arg,
    input  logic [3:0]           imm,
    input  logic [ARG_W-1:0]     saved,
    output logic [BASE_W-1:0]    base
);
    import wrf_pkg::*;

    localparam int EXT_W = (BASE_W > 4) ? BASE_W : 4;

    logic [EXT_W-1:0]  imm_x;
    logic [BASE_W-1:0] base_nxt;

    assign imm_x = EXT_W'($signed(imm));

    always_comb begin
        unique case (op)
            ROT_ADD:     base_nxt = BASE_W'(arg + ARG_W'(base));
            ROT_LOAD:    base_nxt = BASE_W'(arg);
            ROT_IMM:     base_nxt = BASE_W'(imm_x + EXT_W'(base));
            ROT_RESTORE: base_nxt = BASE_W'(saved);
            default:     base_nxt = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) base <= '0;
        else     base <= base_nxt;
    end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int NREGS  = 64,
    parameter int PHYS_W = 6,
    parameter int W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [PHYS_W-1:0] raddr_a,
    output logic [W-1:0]      rdata_a,
    input  logic [PHYS_W-1:0] raddr_b,
    output logic [W-1:0]      rdata_b
);
    logic [W-1:0] mem [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                              mem[g] <= '0;
            else if (we && waddr == PHYS_W'(g))   mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
    parameter int PHYS_REGS = 64,
    parameter int ARG_W     = 8,
    localparam int PHYS_W   = $clog2(PHYS_REGS),
    localparam int BASE_W   = PHYS_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        rot_op,
    input  logic [ARG_W-1:0]  rot_arg,
    input  logic [3:0]        rot_imm,
    input  logic [ARG_W-1:0]  saved_base,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    output logic [BASE_W-1:0] win_base
);
    import wrf_pkg::*;

    localparam int NPORT = 3; // 0: write, 1: read A, 2: read B

    wr_req_t            wreq;
    logic [LIDX_W-1:0]  lidx_v [NPORT];
    logic [PHYS_W-1:0]  pidx_v [NPORT];

    assign wreq = '{en: wr_en, idx: wr_idx, data: wr_data};
    assign lidx_v[0] = wreq.idx;
    assign lidx_v[1] = rd_a_idx;
    assign lidx_v[2] = rd_b_idx;

    wrf_base_ctrl #(.BASE_W(BASE_W), .ARG_W(ARG_W)) u_base (
        .clk   (clk),
        .rst   (rst),
        .op    (rot_op_e'(rot_op)),
        .arg   (rot_arg),
        .imm   (rot_imm),
        .saved (saved_base),
        .base  (win_base)
    );

    // All ports map through the current (pre-update) base.
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_map #(.BASE_W(BASE_W), .PHYS_W(PHYS_W)) u_map (
            .base (win_base),
            .lidx (lidx_v[p]),
            .pidx (pidx_v[p])
        );
    end

    wrf_storage #(.NREGS(PHYS_REGS), .PHYS_W(PHYS_W), .W(WORD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wreq.en),
        .waddr   (pidx_v[0]),
        .wdata   (wreq.data),
        .raddr_a (pidx_v[1]),
        .rdata_a (rd_a_data),
        .raddr_b (pidx_v[2]),
        .rdata_b (rd_b_data)
    );
endmodule

// File: rtl/wrf_top_chk.sv
module wrf_top_chk #(
    parameter int PHYS_REGS = 64,
    parameter int ARG_W     = 8,
    localparam int PHYS_W   = $clog2(PHYS_REGS),
    localparam int BASE_W   = PHYS_W - 2,
    localparam int EXT_W    = (BASE_W > 4) ? BASE_W : 4
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        rot_op,
    input logic [ARG_W-1:0]  rot_arg,
    input logic [3:0]        rot_imm,
    input logic [ARG_W-1:0]  saved_base,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [31:0]       wr_data,
    input logic [3:0]        rd_a_idx,
    input logic [31:0]       rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [31:0]       rd_b_data,
    input logic [BASE_W-1:0] win_base
);
    p_reset_base_r1: assert property (@(posedge clk)
        rst |=> win_base == '0);

    p_add_r4: assert property (@(posedge clk) disable iff (rst)
        rot_op == 3'd1 |=> win_base == BASE_W'($past(rot_arg) + ARG_W'($past(win_base))));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        rot_op == 3'd2 |=> win_base == BASE_W'($past(rot_arg)));

    p_imm_r6: assert property (@(posedge clk) disable iff (rst)
        rot_op == 3'd3 |=> win_base ==
            BASE_W'(EXT_W'($signed($past(rot_imm))) + EXT_W'($past(win_base))));

    p_restore_r7: assert property (@(posedge clk) disable iff (rst)
        rot_op == 3'd4 |=> win_base == BASE_W'($past(saved_base)));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rot_op == 3'd0 || rot_op > 3'd4) |=> $stable(win_base));

    p_ports_agree_r9: assert property (@(posedge clk) disable iff (rst)
        rd_a_idx == rd_b_idx |-> rd_a_data == rd_b_data);

    p_write_seen_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && rd_a_idx == $past(wr_idx)
         && win_base == $past(win_base)) |-> rd_a_data == $past(wr_data));
endmodule

bind wrf_top wrf_top_chk #(.PHYS_REGS(PHYS_REGS), .ARG_W(ARG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rot_op     (rot_op),
    .rot_arg    (rot_arg),
    .rot_imm    (rot_imm),
    .saved_base (saved_base),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .win_base   (win_base)
);

// File: tb/wrf_top_tb_top.sv
`timescale 1ns/1ps
module wrf_top_tb_top;
    localparam int NPHYS = 64;
    localparam int NGRP  = NPHYS / 4;
    localparam int NVEC  = 16;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  arg;
        logic [3:0]  imm;
        logic [7:0]  saved;
        logic        we;
        logic [3:0]  wi;
        logic [31:0] wd;
        logic [3:0]  ra;
        logic [3:0]  rb;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 8'h00, 4'h0, 8'h00, 1'b1, 4'd0,  32'hA000_0000, 4'd0,  4'd1 },
        '{3'd0, 8'h00, 4'h0, 8'h00, 1'b1, 4'd15, 32'hA000_0001, 4'd0,  4'd15},
        '{3'd1, 8'h01, 4'h0, 8'h00, 1'b1, 4'd3,  32'hA000_0002, 4'd15, 4'd3 },
        '{3'd0, 8'h00, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd0,  4'd15},
        '{3'd1, 8'hFF, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd3,  4'd7 },
        '{3'd3, 8'h00, 4'h7, 8'h00, 1'b1, 4'd2,  32'hA000_0003, 4'd2,  4'd15},
        '{3'd3, 8'h00, 4'h8, 8'h00, 1'b0, 4'd0,  32'h0,         4'd0,  4'd2 },
        '{3'd0, 8'h00, 4'h0, 8'h00, 1'b1, 4'd4,  32'hA000_0004, 4'd3,  4'd4 },
        '{3'd2, 8'h23, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd4,  4'd5 },
        '{3'd4, 8'h00, 4'h0, 8'hF1, 1'b1, 4'd1,  32'hA000_0005, 4'd1,  4'd0 },
        '{3'd0, 8'h00, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd12, 4'd0 },
        '{3'd5, 8'h03, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd0,  4'd2 },
        '{3'd7, 8'h05, 4'h5, 8'h09, 1'b1, 4'd15, 32'hA000_0006, 4'd15, 4'd14},
        '{3'd1, 8'h80, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd15, 4'd0 },
        '{3'd2, 8'h00, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd0,  4'd13},
        '{3'd0, 8'h00, 4'h0, 8'h00, 1'b0, 4'd0,  32'h0,         4'd1,  4'd2 }
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rot_op;
    logic [7:0]  rot_arg;
    logic [3:0]  rot_imm;
    logic [7:0]  saved_base;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic [3:0]  rd_a_idx;
    logic [31:0] rd_a_data;
    logic [3:0]  rd_b_idx;
    logic [31:0] rd_b_data;
    logic [3:0]  win_base;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] model [NPHYS];
    int          mbase;

    always #2 clk = ~clk;

    wrf_top #(.PHYS_REGS(NPHYS), .ARG_W(8)) dut_i (
        .clk(clk), .rst(rst), .rot_op(rot_op), .rot_arg(rot_arg),
        .rot_imm(rot_imm), .saved_base(saved_base), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_a_idx(rd_a_idx),
        .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .win_base(win_base)
    );

    function automatic int phys_of(int b, int i);
        return (b * 4 + i) % NPHYS;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NPHYS; k++) model[k] = '0;
        mbase = 0;
    endtask

    task automatic step(vec_t v, string rreq);
        int nb;
        string breq;
        @(negedge clk);
        rot_op = v.op; rot_arg = v.arg; rot_imm = v.imm; saved_base = v.saved;
        wr_en = v.we; wr_idx = v.wi; wr_data = v.wd;
        rd_a_idx = v.ra; rd_b_idx = v.rb;
        #1;
        check({rreq, " port A"}, rd_a_data, model[phys_of(mbase, int'(v.ra))]);
        check({rreq, " port B"}, rd_b_data, model[phys_of(mbase, int'(v.rb))]);
        @(posedge clk);
        if (v.we) model[phys_of(mbase, int'(v.wi))] = v.wd; // old window
        case (v.op)
            3'd1: begin nb = mbase + int'($signed(v.arg));   breq = "R4 base add"; end
            3'd2: begin nb = int'(v.arg) % NGRP;             breq = "R5 base load"; end
            3'd3: begin nb = mbase + int'($signed(v.imm));   breq = "R6 base imm"; end
            3'd4: begin nb = int'(v.saved) % NGRP;           breq = "R7 base restore"; end
            default: begin nb = mbase;                       breq = "R10 base hold"; end
        endcase
        mbase = ((nb % NGRP) + NGRP) % NGRP;
        #1;
        check(breq, 32'(win_base), 32'(mbase));
    endtask

    function automatic vec_t mk(logic [2:0] op, logic [7:0] arg, logic we,
                                logic [3:0] wi, logic [31:0] wd,
                                logic [3:0] ra, logic [3:0] rb);
        vec_t v;
        v = '{op: op, arg: arg, imm: 4'h0, saved: 8'h00, we: we, wi: wi,
              wd: wd, ra: ra, rb: rb};
        return v;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; rot_op = '0; rot_arg = '0; rot_imm = '0; saved_base = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_a_idx = '0; rd_b_idx = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state seen at the ports
        check("R1 base after reset", 32'(win_base), 32'd0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i); #1;
            check("R1 cleared reg A", rd_a_data, 32'd0);
            check("R1 cleared reg B", rd_b_data, 32'd0);
        end

        // Vector table: R2 mapping and R9 read-after-write across base moves
        for (int n = 0; n < NVEC; n++) step(VECS[n], "R2/R9 read");

        // R3: fill window at base 14 crossing the top, view from base 0
        step(mk(3'd2, 8'd14, 1'b0, 4'd0, 32'h0, 4'd0, 4'd0), "R2 read");
        for (int i = 0; i < 16; i++)
            step(mk(3'd0, 8'd0, 1'b1, 4'(i), 32'hC000_0000 + 32'(i), 4'd0, 4'd0), "R3 read");
        step(mk(3'd2, 8'd0, 1'b0, 4'd0, 32'h0, 4'd0, 4'd0), "R3 read");
        for (int i = 0; i < 8; i++)
            step(mk(3'd0, 8'd0, 1'b0, 4'd0, 32'h0, 4'(i), 4'(7 - i)), "R3 wrap read");
        @(negedge clk); rd_a_idx = 4'd0; rd_b_idx = 4'd7; #1;
        check("R3 phys0 from logical8@14", rd_a_data, 32'hC000_0008);
        check("R3 phys7 from logical15@14", rd_b_data, 32'hC000_000F);

        // R8: write together with rotation lands in the old window
        step(mk(3'd2, 8'd5, 1'b0, 4'd0, 32'h0, 4'd0, 4'd0), "R2 read");
        step(mk(3'd1, 8'd2, 1'b1, 4'd1, 32'hBEEF_0008, 4'd0, 4'd0), "R8 read");
        step(mk(3'd1, 8'hFE, 1'b0, 4'd0, 32'h0, 4'd1, 4'd9), "R8 read");
        @(negedge clk); rd_a_idx = 4'd1; rd_b_idx = 4'd9; #1;
        check("R8 old window target", rd_a_data, 32'hBEEF_0008);
        check("R8 new window untouched", rd_b_data, 32'd0);

        // R1: reset after data written clears storage and base
        @(negedge clk); rst = 1'b1; rot_op = 3'd1; rot_arg = 8'd3; wr_en = 1'b0;
        @(posedge clk); #1;
        check("R1 base in reset", 32'(win_base), 32'd0);
        @(negedge clk); rst = 1'b0; rot_op = 3'd0;
        model_reset();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); rd_a_idx = 4'(i); rd_b_idx = 4'(i); #1;
            check("R1 cleared after data", rd_a_data, 32'd0);
        end
        step(mk(3'd2, 8'd14, 1'b0, 4'd0, 32'h0, 4'd0, 4'd0), "R1 read");
        for (int i = 0; i < 16; i++)
            step(mk(3'd0, 8'd0, 1'b0, 4'd0, 32'h0, 4'(i), 4'(15 - i)), "R1 read");

        finish_run();
    end
endmodule